// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from two groups: a core interface group of 8 levels and a peripheral bus group of 32 levels. It latches them into sticky pending bits, applies one enable bit per level and picks the most urgent enabled request. It then presents that level to the processor with a single request line, a level number and a handler address. Software reaches the controller through a small word-wide register port. That port holds a control word, the pending words, the enable words, the in-service status words and a handler table base.

The controller comes out of reset in a compatible 8-level mode. In that mode only the core group takes part and the handler address is a plain code derived from the level. Setting the enhanced-mode control bit opens all 40 levels. A second pair of control bits turns the handler address into an entry of a relocatable branch table, one 8-byte slot per level, so the handler does not need to decode which level fired. A further control bit turns on hardware nesting. When the processor accepts an interrupt, that level is marked in service, and from then on only strictly more urgent levels can raise a request. An end-of-interrupt write retires the most urgent in-service level, which lets an interrupted handler of lower priority resume.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, the controller is in the 8-level mode and `irq` is low.
- R2: A request input that is high at a clock edge sets its pending bit at that edge, and the bit stays set until software writes 1 to it. Pending levels 0–31 are at address 1 and levels 32–39 are in bits 7:0 of address 2. If a request and a write-1-to-clear hit the same bit in the same cycle, the bit stays set.
- R3: While control bit 0 (enhanced) is clear, levels 8–39 are neither latched nor selected, and `ack` never changes the in-service state.
- R4: Level 0 is the most urgent. `irq_level` is the lowest-numbered level that is both pending and enabled, and a level is enabled by a 1 in the enable words: address 3 for levels 0–31 and address 4 bits 7:0 for levels 32–39.
- R5: When control bits 0, 1 (relocate) and 2 (relocate prerequisite) are all set, `irq_vector` equals table base + 8 × `irq_level`. Otherwise `irq_vector` equals 4 × `irq_level`.
- R6: With control bits 0 and 3 (nesting) both set, an `ack` while `irq` is high sets the in-service bit of `irq_level` at that clock edge. `irq` is then high only when the winning level is more urgent than every in-service level.
- R7: A write to address 8 (end of interrupt) clears the lowest-numbered in-service bit. When an `ack` falls in the same cycle, the clear acts on the old status and the new level is then added.
- R8: With nesting off, `irq` is high whenever any level is pending and enabled, and `ack` leaves the in-service state unchanged.
- R9: In-service status reads at address 5 (levels 0–31) and at address 6 bits 7:0 (levels 32–39). The control word reads at address 0, and the table base at address 7 always reads with bits 2:0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 8 | Core group requests, levels 0–7 |
| periph_req | input | 32 | Peripheral group requests, levels 8–39 |
| ack | input | 1 | Processor accepts the presented interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request to the processor |
| irq_level | output | 6 | Winning level number |
| irq_vector | output | 32 | Handler address or compatible code |

## Verification
Two pairs of events can land on the same clock edge. An end-of-interrupt write can coincide with an `ack` of a new, more urgent level, and a live request can coincide with a software clear of the same pending bit. The bench forces both coincidences on purpose, with the nesting stack two deep and with a request held high during the clear. It then judges the status and pending words it reads back against the rule "clear from the old state, then set", and against the rule that the set wins. Random rounds in both modes compare the winner and the vector with a bench model.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_SEL_W = 4;

    typedef enum logic [ADDR_SEL_W-1:0] {
        A_CTRL    = 4'd0,
        A_PEND_LO = 4'd1,
        A_PEND_HI = 4'd2,
        A_MASK_LO = 4'd3,
        A_MASK_HI = 4'd4,
        A_SVC_LO  = 4'd5,
        A_SVC_HI  = 4'd6,
        A_TBASE   = 4'd7,
        A_EOI     = 4'd8
    } reg_sel_e;

    // Control word, bit 0 is enh
    typedef struct packed {
        logic nest;
        logic reloc_pre;
        logic reloc_en;
        logic enh;
    } ctrl_t;

    typedef struct packed {
        logic       valid;
        logic [5:0] idx;
    } first_t;

    // Lowest set bit of a vector of up to 64 levels
    function automatic first_t first_set(logic [63:0] v);
        first_t r;
        r = '0;
        for (int i = 63; i >= 0; i--) begin
            if (v[i]) begin
                r.valid = 1'b1;
                r.idx   = 6'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/nic_regs.sv
module nic_regs
    import nic_pkg::*;
#(
    parameter int NUM_CORE   = 8,
    parameter int NUM_PERIPH = 32,
    parameter int ADDR_W     = 32,
    localparam int NL        = NUM_CORE + NUM_PERIPH,
    localparam int LVL_W     = $clog2(NL)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NL-1:0]         req,
    input  logic                  we,
    input  logic [ADDR_SEL_W-1:0] addr,
    input  logic [WORD_W-1:0]     wdata,
    input  logic                  take,
    input  logic [LVL_W-1:0]      take_lvl,
    output logic [WORD_W-1:0]     rdata,
    output ctrl_t                 ctrl,
    output logic [NL-1:0]         pend,
    output logic [NL-1:0]         mask,
    output logic [NL-1:0]         insvc,
    output logic [NL-1:0]         allowed,
    output logic [ADDR_W-1:0]     tbase
);

    logic [NL-1:0] pend_n, mask_n, insvc_n, clr_pend, svc_clr, svc_set;
    logic [63:0]   m64, c64;
    logic          eoi;
    first_t        top_svc;

    assign allowed = ctrl.enh ? '1 : NL'((64'd1 << NUM_CORE) - 64'd1);
    assign eoi     = we && (addr == A_EOI);
    assign top_svc = first_set(64'(insvc));

    always_comb begin
        c64 = '0;
        if (we && addr == A_PEND_LO) c64[31:0]  = wdata;
        if (we && addr == A_PEND_HI) c64[63:32] = wdata;
        clr_pend = NL'(c64);
        pend_n   = (pend & ~clr_pend) | (req & allowed);

        m64 = 64'(mask);
        if (we && addr == A_MASK_LO) m64[31:0]  = wdata;
        if (we && addr == A_MASK_HI) m64[63:32] = wdata;
        mask_n = NL'(m64);

        svc_clr = (eoi && top_svc.valid) ? NL'(64'd1 << top_svc.idx) : '0;
        svc_set = take ? NL'(64'd1 << take_lvl) : '0;
        insvc_n = (insvc & ~svc_clr) | svc_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            pend  <= '0;
            mask  <= '0;
            insvc <= '0;
            tbase <= '0;
        end else begin
            pend  <= pend_n;
            mask  <= mask_n;
            insvc <= insvc_n;
            if (we && addr == A_CTRL)  ctrl  <= ctrl_t'(wdata[3:0]);
            if (we && addr == A_TBASE) tbase <= ADDR_W'(wdata) & ~ADDR_W'(7);
        end
    end

    always_comb begin
        unique case (addr)
            A_CTRL:    rdata = WORD_W'(ctrl);
            A_PEND_LO: rdata = pend[31:0];
            A_PEND_HI: rdata = WORD_W'(64'(pend) >> 32);
            A_MASK_LO: rdata = mask[31:0];
            A_MASK_HI: rdata = WORD_W'(64'(mask) >> 32);
            A_SVC_LO:  rdata = insvc[31:0];
            A_SVC_HI:  rdata = WORD_W'(64'(insvc) >> 32);
            A_TBASE:   rdata = WORD_W'(tbase);
            default:   rdata = '0;
        endcase
    end

    // R2
    pend_latch_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((pend & $past(req & allowed)) == $past(req & allowed)));

    // R7
    eoi_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi && !take && top_svc.valid) |=> ($countones(insvc) == $countones($past(insvc)) - 1));

endmodule

// File: rtl/nic_prio.sv
module nic_prio
    import nic_pkg::*;
#(
    parameter int NUM_CORE   = 8,
    parameter int NUM_PERIPH = 32,
    localparam int NL        = NUM_CORE + NUM_PERIPH,
    localparam int LVL_W     = $clog2(NL)
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [NL-1:0]    pend,
    input  logic [NL-1:0]    mask,
    input  logic [NL-1:0]    insvc,
    input  logic [NL-1:0]    allowed,
    output logic             irq,
    output logic             nest_on,
    output logic [LVL_W-1:0] lvl
);

    logic [NL-1:0] active;
    first_t        win, top;

    assign active  = pend & mask & allowed;
    assign win     = first_set(64'(active));
    assign top     = first_set(64'(insvc));
    assign nest_on = ctrl.enh && ctrl.nest;
    assign lvl     = LVL_W'(win.idx);
    assign irq     = win.valid && (!nest_on || !top.valid || (win.idx < top.idx));

    // R4
    winner_live_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pend[lvl] && mask[lvl]));

    // R3
    legacy_range_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !ctrl.enh) |-> (lvl < LVL_W'(NUM_CORE)));

    // R6
    nest_block_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && nest_on) |-> !insvc[lvl]);

endmodule

// File: rtl/nic_vector.sv
module nic_vector
    import nic_pkg::*;
#(
    parameter int LVL_W  = 6,
    parameter int ADDR_W = 32
) (
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] tbase,
    input  logic [LVL_W-1:0]  lvl,
    output logic [ADDR_W-1:0] vector
);

    localparam int SLOT_SH = 3;
    localparam int CODE_SH = 2;

    logic reloc;
    assign reloc  = ctrl.enh && ctrl.reloc_en && ctrl.reloc_pre;
    assign vector = reloc ? tbase + (ADDR_W'(lvl) << SLOT_SH)
                          : ADDR_W'(lvl) << CODE_SH;

endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_CORE   = 8,
    parameter int NUM_PERIPH = 32,
    parameter int ADDR_W     = 32,
    localparam int NL        = NUM_CORE + NUM_PERIPH,
    localparam int LVL_W     = $clog2(NL)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CORE-1:0]   core_req,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic                  ack,
    input  logic                  reg_we,
    input  logic [3:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  irq,
    output logic [LVL_W-1:0]      irq_level,
    output logic [ADDR_W-1:0]     irq_vector
);

    ctrl_t             ctrl;
    logic [NL-1:0]     pend, mask, insvc, allowed;
    logic [ADDR_W-1:0] tbase;
    logic              nest_on, take;

    assign take = ack && irq && nest_on;

    nic_regs #(.NUM_CORE(NUM_CORE), .NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .req({periph_req, core_req}),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .take(take), .take_lvl(irq_level), .rdata(reg_rdata),
        .ctrl(ctrl), .pend(pend), .mask(mask), .insvc(insvc),
        .allowed(allowed), .tbase(tbase)
    );

    nic_prio #(.NUM_CORE(NUM_CORE), .NUM_PERIPH(NUM_PERIPH)) u_prio (
        .clk(clk), .rst(rst), .ctrl(ctrl), .pend(pend), .mask(mask),
        .insvc(insvc), .allowed(allowed), .irq(irq), .nest_on(nest_on), .lvl(irq_level)
    );

    nic_vector #(.LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_vec (
        .ctrl(ctrl), .tbase(tbase), .lvl(irq_level), .vector(irq_vector)
    );

    // R6
    take_mark_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> insvc[$past(irq_level)]);

    // R8
    no_take_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !nest_on && !(reg_we && reg_addr == 4'd8)) |=> $stable(insvc));

endmodule

// File: tb/test_nested_irq_ctrl.sv
module test_nested_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  core_req = '0;
    logic [31:0] periph_req = '0;
    logic        ack = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [5:0]  irq_level;
    logic [31:0] irq_vector;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nested_irq_ctrl i_nested_irq_ctrl (
        .clk(clk), .rst(rst), .core_req(core_req), .periph_req(periph_req),
        .ack(ack), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .irq_level(irq_level), .irq_vector(irq_vector)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_req(logic [39:0] r);
        {periph_req, core_req} = r;
        step();
        {periph_req, core_req} = '0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        step();
        ack = 1'b0;
    endtask

    function automatic int model_win(logic [39:0] act);
        for (int i = 0; i < 40; i++) if (act[i]) return i;
        return -1;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), d);
            chk("R1 reg reset", d, 0);
        end
        chk("R1 irq reset", irq, 0);

        // R3 legacy: level 3 wins, peripheral level 10 not latched
        wr(4'd3, 32'hFFFF_FFFF);
        pulse_req(40'h0000_0004_08);
        rd(4'd1, d);
        chk("R3 legacy periph ignored", d, 32'h0000_0008);
        chk("R4 legacy irq", irq, 1);
        chk("R4 legacy level", irq_level, 3);
        chk("R5 legacy code", irq_vector, 12);
        do_ack();
        rd(4'd5, d);
        chk("R3 legacy ack no status", d, 0);

        // R2 set wins over clear, then clear
        core_req[1] = 1'b1;
        step();
        wr(4'd1, 32'h2);
        rd(4'd1, d);
        chk("R2 set beats clear", d[1], 1);
        core_req[1] = 1'b0;
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, d);
        chk("R2 w1c", d, 0);
        chk("R2 irq gone", irq, 0);

        // R5 relocation, needs all three bits
        wr(4'd7, 32'h1000_0005);
        rd(4'd7, d);
        chk("R9 base low bits", d, 32'h1000_0000);
        wr(4'd0, 32'h1);
        wr(4'd4, 32'h20);
        pulse_req(40'h20_0000_0000);
        rd(4'd2, d);
        chk("R2 hi pending", d, 32'h20);
        chk("R4 level 37", irq_level, 37);
        chk("R5 no reloc", irq_vector, 148);
        wr(4'd0, 32'h3);
        chk("R5 reloc w/o prereq", irq_vector, 148);
        wr(4'd0, 32'h7);
        chk("R5 reloc vector", irq_vector, 32'h1000_0128);
        rd(4'd0, d);
        chk("R9 ctrl read", d, 7);

        // R8 nesting off: ack ignored
        do_ack();
        rd(4'd6, d);
        chk("R8 no status hi", d, 0);
        chk("R8 irq stays", irq, 1);
        wr(4'd2, 32'hFF);

        // R6 nesting on
        wr(4'd0, 32'h9);
        wr(4'd4, 32'hFF);
        pulse_req(40'h20);
        chk("R6 irq lvl5", irq_level, 5);
        do_ack();
        rd(4'd5, d);
        chk("R6 svc5", d, 32'h20);
        chk("R6 same level blocked", irq, 0);
        pulse_req(40'h200);
        chk("R6 lower blocked", irq, 0);
        pulse_req(40'h4);
        chk("R6 higher irq", irq, 1);
        chk("R6 higher level", irq_level, 2);
        do_ack();
        rd(4'd5, d);
        chk("R9 svc two deep", d, 32'h24);
        wr(4'd1, 32'h4);
        chk("R6 irq blocked by 2", irq, 0);
        wr(4'd8, 0);
        rd(4'd5, d);
        chk("R7 eoi clears top", d, 32'h20);
        chk("R7 lvl5 still blocked", irq, 0);

        // R7 ack and eoi in the same cycle
        pulse_req(40'h4);
        chk("R6 lvl2 again", irq, 1);
        ack = 1'b1;
        wr(4'd8, 0);
        ack = 1'b0;
        rd(4'd5, d);
        chk("R7 eoi+ack", d, 32'h04);
        wr(4'd8, 0);
        rd(4'd5, d);
        chk("R7 empty", d, 0);
        chk("R6 irq after eoi", irq_level, 2);

        // random rounds, nesting off
        for (int it = 0; it < 150; it++) begin
            logic [39:0] r, m, allow, exp_p;
            logic        enh;
            int          w;
            enh = it[0];
            wr(4'd0, enh ? 32'h7 : 32'h0);
            wr(4'd1, 32'hFFFF_FFFF);
            wr(4'd2, 32'hFFFF_FFFF);
            m = {8'($urandom), 32'($urandom)};
            wr(4'd3, m[31:0]);
            wr(4'd4, {24'h0, m[39:32]});
            r = {8'($urandom), 32'($urandom)} & {8'($urandom), 32'($urandom)};
            pulse_req(r);
            allow = enh ? '1 : 40'hFF;
            exp_p = r & allow;
            rd(4'd1, d);
            chk("R2 rand pend", d, exp_p[31:0]);
            w = model_win(exp_p & m);
            chk("R8 rand irq", irq, (w >= 0));
            if (w >= 0) begin
                chk("R4 rand level", irq_level, w);
                chk("R5 rand vector", irq_vector,
                    enh ? 32'h1000_0000 + 32'(w) * 8 : 32'(w) * 4);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule